// File: doc/BRIEF.md
# Readout Trigger and Command Sequencer

The sequencer sits at the centre of the readout timing system and runs at the bunch-crossing rate. Each cycle it merges the low-level trigger decision, the internally generated periodic and calibration requests, the throttle and pause controls and a set of command requests. From these it builds one 64-bit control word. That word is sent out a fixed, build-time number of cycles later, so downstream electronics can associate every command with the crossing it names.

A free-running bunch counter indexes a one-bit-per-crossing filling-scheme memory, which is loaded through a simple write port. A set entry vetoes the readout of that crossing. Reset commands and non-zero-suppressed readout both open windows in which the word asks the receivers to send headers only, so that their buffers can recover. The lengths of these windows are configurable.

Top module: `rs_cmd_sequencer`

## Requirements
- R1: While rst_n is low the output word is all zero.
- R2: Bits 63..52 carry a bunch number that starts at 0 after reset and counts up by one each cycle, wrapping from ORBIT-1 (3563) to 0. Bit 5, the bunch-number reset, is set exactly in the words whose bunch number is 0.
- R3: Bit 1, the crossing veto, equals the filling-scheme entry for the word's bunch number, where 1 means vetoed and all entries are 0 after reset. A write on the fs port changes an entry from the following cycle on. A vetoed word also has bit 3 (header-only) set. The veto has no effect on the trigger fields.
- R4: Bit 0 is set when at least one trigger source is active. Priority is calibration, then periodic, then the low-level decision. The trigger-type field in bits 13..10 is 4'hE for calibration, 4'hD for periodic, and llt_type otherwise. Bits 17..14 carry cal_type only for a calibration trigger. Bits 49..18 carry dest whenever bit 0 is set. All four of these fields are zero when bit 0 is clear.
- R5: While throttle is high, every trigger from any source becomes a reject: bit 0, the type, calibration and destination fields, and the NZS bit are all zero.
- R6: While pause is high, triggers are rejected as under R5, and the bunch number and command flags continue unchanged.
- R7: The cmd_req bits map to command flags as follows: bit 0 front-end reset to word bit 6, bit 1 back-end reset to bit 4, bit 2 event-number reset to bit 7, bit 3 synch to bit 8, bit 4 snapshot to bit 9. A flag is set for one cycle only, in the cycle in which its request rises. A request held high produces no further flags.
- R8: After a front-end reset flag, header-only is set for the next fe_wm cycles. After a back-end reset flag, it is set for the next be_wm cycles. A new flag reloads the window.
- R9: Bit 2 (NZS) is set when a trigger is accepted with nzs_req high and no NZS wait is pending. During a wait the trigger is still accepted, but without NZS.
- R10: An NZS wait of nzs_wait cycles, during which header-only is set, begins in the cycle after the nzs_burst-th consecutive NZS event. It also begins two cycles after the last event of a shorter run, that is, in the cycle after the first cycle without an event.
- R11: The word built from the inputs of one cycle appears at tfc_word OUT_LAT clock edges later. Bits 51..50 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| llt_yes | input | 1 | Low-level trigger accept |
| llt_type | input | 4 | Trigger type of the low-level accept |
| per_req | input | 1 | Periodic trigger request |
| cal_req | input | 1 | Calibration trigger request |
| cal_type | input | 4 | Calibration pulse type |
| nzs_req | input | 1 | Ask for non-zero-suppressed readout of this trigger |
| dest | input | 32 | Event destination attached to accepted triggers |
| throttle | input | 1 | Reject all triggers while high |
| pause | input | 1 | Run pause, rejects all triggers |
| cmd_req | input | 5 | Command requests (see R7) |
| fe_wm | input | WM_W | Header-only cycles after a front-end reset |
| be_wm | input | WM_W | Header-only cycles after a back-end reset |
| nzs_wait | input | WM_W | Header-only cycles of an NZS wait |
| nzs_burst | input | BURST_W | Consecutive NZS events allowed before a wait |
| fs_we | input | 1 | Filling-scheme write enable |
| fs_addr | input | 12 | Filling-scheme entry address |
| fs_data | input | 1 | Filling-scheme entry value (1 = vetoed) |
| tfc_word | output | 64 | Delayed control word |

## Verification
Several sources can drive header-only in the same cycle, and the bench provokes this deliberately. A front-end reset request rises in the middle of an NZS burst, so the reset window and the NZS wait overlap, and crossings marked in the filling scheme are passed while triggers and windows are active. A calibration request also arrives together with throttle, and another together with a periodic and a low-level accept. In each case the scoreboard forms the expected word from its own model of every window counter and every priority rule. It then compares the whole 64-bit word at the delayed cycle, so an overlap that drops or duplicates a flag shows up as a field mismatch.

// File: rtl/rs_seq_pkg.sv
package rs_seq_pkg;

  localparam int WORD_W  = 64;
  localparam int BX_W    = 12;
  localparam int NUM_CMD = 5;

  // flag positions inside the control word (decoded downstream)
  localparam int F_TRIG   = 0;
  localparam int F_VETO   = 1;
  localparam int F_NZS    = 2;
  localparam int F_HDR    = 3;
  localparam int F_BERST  = 4;
  localparam int F_BXRST  = 5;
  localparam int F_FERST  = 6;
  localparam int F_EIDRST = 7;
  localparam int F_SYNCH  = 8;
  localparam int F_SNAP   = 9;

  // command request indices
  localparam int CMD_FE    = 0;
  localparam int CMD_BE    = 1;
  localparam int CMD_EID   = 2;
  localparam int CMD_SYNCH = 3;
  localparam int CMD_SNAP  = 4;

  localparam logic [3:0] TT_PERIODIC = 4'hD;
  localparam logic [3:0] TT_CALIB    = 4'hE;

  typedef struct packed {
    logic [BX_W-1:0] bx;
    logic [1:0]      spare;
    logic [31:0]     dest;
    logic [3:0]      cal;
    logic [3:0]      ttype;
    logic [9:0]      flags;
  } rs_word_t;

endpackage

// File: rtl/rs_bx_track.sv
module rs_bx_track
  import rs_seq_pkg::*;
#(
  parameter int ORBIT = 3564
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fs_we,
  input  logic [BX_W-1:0] fs_addr,
  input  logic            fs_data,
  output logic [BX_W-1:0] bx,
  output logic            veto,
  output logic            orbit_start
);

  localparam logic [BX_W-1:0] BX_LAST = BX_W'(ORBIT - 1);
  localparam logic [BX_W-1:0] BX_LIM  = BX_W'(ORBIT);

  logic [BX_W-1:0]  bx_q, bx_d;
  logic [ORBIT-1:0] fill_q, fill_d;
  logic             fill_en;

  assign fill_en = fs_we && (fs_addr < BX_LIM);

  always_comb begin
    bx_d = (bx_q == BX_LAST) ? '0 : bx_q + 1'b1;
  end

  always_comb begin
    fill_d = fill_q;
    if (fill_en) fill_d[fs_addr] = fs_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bx_q <= '0;
    else        bx_q <= bx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fill_q <= '0;
    else if (fill_en) fill_q <= fill_d;
  end

  assign bx          = bx_q;
  assign veto        = fill_q[bx_q];
  assign orbit_start = (bx_q == '0);

  AST_BX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bx_q == BX_LAST) |=> (bx_q == '0)); // R2
  AST_BX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bx_q != BX_LAST) |=> (bx_q == $past(bx_q) + 1'b1)); // R2
  AST_FILL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (fill_q[$past(fs_addr)] == $past(fs_data))); // R3

endmodule

// File: rtl/rs_cmd_handler.sv
module rs_cmd_handler #(
  parameter int WM_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [WM_W-1:0] wm,
  output logic            flag,
  output logic            hold
);

  logic            prev_q;
  logic [WM_W-1:0] cnt_q, cnt_d;

  assign flag = req & ~prev_q;
  assign hold = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (flag)      cnt_d = wm;
    else if (hold) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= req;
      cnt_q  <= cnt_d;
    end
  end

  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> !flag); // R7
  AST_CMD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && (wm != '0)) |=> hold); // R8

endmodule

// File: rtl/rs_nzs_ctrl.sv
module rs_nzs_ctrl #(
  parameter int CNT_W   = 8,
  parameter int BURST_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nzs_req,
  input  logic [BURST_W-1:0] burst,
  input  logic [CNT_W-1:0]   wait_len,
  output logic               nzs_evt,
  output logic               hold
);

  logic [BURST_W-1:0] run_q, run_d;
  logic [CNT_W-1:0]   hold_q, hold_d;
  logic               burst_done;

  assign hold       = (hold_q != '0);
  assign nzs_evt    = nzs_req & ~hold;
  assign burst_done = ({1'b0, run_q} + 1'b1) >= {1'b0, burst};

  always_comb begin
    run_d  = run_q;
    hold_d = hold ? hold_q - 1'b1 : hold_q;
    if (nzs_evt) begin
      if (burst_done) begin
        run_d  = '0;
        hold_d = wait_len;
      end else begin
        run_d  = run_q + 1'b1;
      end
    end else if (run_q != '0) begin
      run_d  = '0;
      hold_d = wait_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      hold_q <= '0;
    end else begin
      run_q  <= run_d;
      hold_q <= hold_d;
    end
  end

  AST_NZS_WAIT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (nzs_evt && burst_done && (wait_len != '0)) |=> hold); // R10
  AST_NZS_RUN_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!nzs_evt && (run_q != '0) && (wait_len != '0)) |=> (hold && (run_q == '0))); // R10

endmodule

// File: rtl/rs_out_pipe.sv
module rs_out_pipe #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q[0] <= '0;
    else        st_q[0] <= d;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[g] <= '0;
      else        st_q[g] <= st_q[g-1];
    end

    AST_PIPE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[g] == $past(st_q[g-1])); // R11
  end

  assign q = st_q[DEPTH-1];

endmodule

// File: rtl/rs_cmd_sequencer.sv
module rs_cmd_sequencer
  import rs_seq_pkg::*;
#(
  parameter int ORBIT   = 3564,
  parameter int OUT_LAT = 4,
  parameter int WM_W    = 8,
  parameter int BURST_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               llt_yes,
  input  logic [3:0]         llt_type,
  input  logic               per_req,
  input  logic               cal_req,
  input  logic [3:0]         cal_type,
  input  logic               nzs_req,
  input  logic [31:0]        dest,
  input  logic               throttle,
  input  logic               pause,
  input  logic [NUM_CMD-1:0] cmd_req,
  input  logic [WM_W-1:0]    fe_wm,
  input  logic [WM_W-1:0]    be_wm,
  input  logic [WM_W-1:0]    nzs_wait,
  input  logic [BURST_W-1:0] nzs_burst,
  input  logic               fs_we,
  input  logic [BX_W-1:0]    fs_addr,
  input  logic               fs_data,
  output logic [WORD_W-1:0]  tfc_word
);

  logic [BX_W-1:0]    bx;
  logic               veto, orbit_start;
  logic [NUM_CMD-1:0] cmd_flag, cmd_hold;
  logic [WM_W-1:0]    cmd_wm [NUM_CMD];
  logic               src_any, trig_acc;
  logic               nzs_evt, nzs_hold;
  rs_word_t           word_d;

  rs_bx_track #(.ORBIT(ORBIT)) u_bx (
    .clk         (clk),
    .rst_n       (rst_n),
    .fs_we       (fs_we),
    .fs_addr     (fs_addr),
    .fs_data     (fs_data),
    .bx          (bx),
    .veto        (veto),
    .orbit_start (orbit_start)
  );

  always_comb begin
    for (int k = 0; k < NUM_CMD; k++) cmd_wm[k] = '0;
    cmd_wm[CMD_FE] = fe_wm;
    cmd_wm[CMD_BE] = be_wm;
  end

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_cmd
    rs_cmd_handler #(.WM_W(WM_W)) u_cmd (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (cmd_req[g]),
      .wm    (cmd_wm[g]),
      .flag  (cmd_flag[g]),
      .hold  (cmd_hold[g])
    );
  end

  assign src_any  = cal_req | per_req | llt_yes;
  assign trig_acc = src_any & ~throttle & ~pause;

  rs_nzs_ctrl #(.CNT_W(WM_W), .BURST_W(BURST_W)) u_nzs (
    .clk      (clk),
    .rst_n    (rst_n),
    .nzs_req  (trig_acc & nzs_req),
    .burst    (nzs_burst),
    .wait_len (nzs_wait),
    .nzs_evt  (nzs_evt),
    .hold     (nzs_hold)
  );

  always_comb begin
    word_d                 = '0;
    word_d.bx              = bx;
    word_d.flags[F_TRIG]   = trig_acc;
    word_d.flags[F_VETO]   = veto;
    word_d.flags[F_NZS]    = nzs_evt;
    word_d.flags[F_HDR]    = veto | (|cmd_hold) | nzs_hold;
    word_d.flags[F_BERST]  = cmd_flag[CMD_BE];
    word_d.flags[F_BXRST]  = orbit_start;
    word_d.flags[F_FERST]  = cmd_flag[CMD_FE];
    word_d.flags[F_EIDRST] = cmd_flag[CMD_EID];
    word_d.flags[F_SYNCH]  = cmd_flag[CMD_SYNCH];
    word_d.flags[F_SNAP]   = cmd_flag[CMD_SNAP];
    if (trig_acc) begin
      word_d.dest = dest;
      if (cal_req) begin
        word_d.ttype = TT_CALIB;
        word_d.cal   = cal_type;
      end else if (per_req) begin
        word_d.ttype = TT_PERIODIC;
      end else begin
        word_d.ttype = llt_type;
      end
    end
  end

  rs_out_pipe #(.W(WORD_W), .DEPTH(OUT_LAT)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (word_d),
    .q     (tfc_word)
  );

  AST_VETO_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    word_d.flags[F_VETO] |-> word_d.flags[F_HDR]); // R3
  AST_THROTTLE_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    throttle |-> (!word_d.flags[F_TRIG] && (word_d.dest == '0) && !word_d.flags[F_NZS])); // R5
  AST_PAUSE_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    pause |-> (!word_d.flags[F_TRIG] && (word_d.ttype == '0))); // R6
  AST_CAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req && !throttle && !pause) |-> ((word_d.ttype == TT_CALIB) && (word_d.cal == cal_type))); // R4

endmodule

// File: tb/rs_cmd_sequencer_tb.sv
`timescale 1ns/1ps
module rs_cmd_sequencer_tb;

  localparam int ORBIT   = 3564;
  localparam int LAT     = 4;
  localparam int WM_W    = 8;
  localparam int BURST_W = 4;
  localparam int NCMD    = 5;

  logic               clk;
  logic               rst_n;
  logic               llt_yes;
  logic [3:0]         llt_type;
  logic               per_req;
  logic               cal_req;
  logic [3:0]         cal_type;
  logic               nzs_req;
  logic [31:0]        dest;
  logic               throttle;
  logic               pause;
  logic [NCMD-1:0]    cmd_req;
  logic [WM_W-1:0]    fe_wm, be_wm, nzs_wait;
  logic [BURST_W-1:0] nzs_burst;
  logic               fs_we;
  logic [11:0]        fs_addr;
  logic               fs_data;
  logic [63:0]        tfc_word;

  rs_cmd_sequencer #(.ORBIT(ORBIT), .OUT_LAT(LAT), .WM_W(WM_W), .BURST_W(BURST_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .llt_yes(llt_yes), .llt_type(llt_type),
    .per_req(per_req), .cal_req(cal_req), .cal_type(cal_type), .nzs_req(nzs_req),
    .dest(dest), .throttle(throttle), .pause(pause), .cmd_req(cmd_req),
    .fe_wm(fe_wm), .be_wm(be_wm), .nzs_wait(nzs_wait), .nzs_burst(nzs_burst),
    .fs_we(fs_we), .fs_addr(fs_addr), .fs_data(fs_data), .tfc_word(tfc_word)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int          n_chk  = 0;
  int          n_fail = 0;
  bit          ended  = 0;
  logic [63:0] exp_q [$];
  logic [63:0] mon_e;

  // reference state, built from the requirements
  int bx_m   = 0;
  bit fill_m [ORBIT];
  bit prev_m [NCMD];
  int win_m  [NCMD];
  int run_m  = 0;
  int hold_m = 0;

  function automatic string req_of(int b);
    if (b == 1)                          return "R3";
    if (b == 2)                          return "R9";
    if (b == 3)                          return "R3/R8/R10";
    if (b == 5 || b >= 52)               return "R2";
    if (b == 4 || (b >= 6 && b <= 9))    return "R7";
    if (b == 50 || b == 51)              return "R11";
    return "R4/R5/R6";
  endfunction

  task automatic clr();
    llt_yes = 0; llt_type = '0; per_req = 0; cal_req = 0; cal_type = '0;
    nzs_req = 0; dest = '0; throttle = 0; pause = 0; fs_we = 0;
    fs_addr = '0; fs_data = 0;
  endtask

  // driver: predicts the word for the current inputs, queues it, advances the model
  task automatic cyc();
    logic [63:0] e;
    bit acc, nz;
    bit fl [NCMD];
    int nh;
    e   = '0;
    acc = (cal_req || per_req || llt_yes) && !throttle && !pause;
    nz  = acc && nzs_req && (hold_m == 0);
    for (int k = 0; k < NCMD; k++) fl[k] = cmd_req[k] && !prev_m[k];
    e[0] = acc;
    e[1] = fill_m[bx_m];
    e[2] = nz;
    e[3] = fill_m[bx_m] || (win_m[0] > 0) || (win_m[1] > 0) || (hold_m > 0);
    e[4] = fl[1];
    e[5] = (bx_m == 0);
    e[6] = fl[0];
    e[7] = fl[2];
    e[8] = fl[3];
    e[9] = fl[4];
    if (acc) begin
      if (cal_req) begin
        e[13:10] = 4'hE;
        e[17:14] = cal_type;
      end else if (per_req) e[13:10] = 4'hD;
      else e[13:10] = llt_type;
      e[49:18] = dest;
    end
    e[63:52] = 12'(bx_m);
    exp_q.push_back(e);
    for (int k = 0; k < NCMD; k++) begin
      if (fl[k]) win_m[k] = (k == 0) ? int'(fe_wm) : (k == 1) ? int'(be_wm) : 0;
      else if (win_m[k] > 0) win_m[k] = win_m[k] - 1;
      prev_m[k] = cmd_req[k];
    end
    nh = (hold_m > 0) ? hold_m - 1 : hold_m;
    if (nz) begin
      if (run_m + 1 >= int'(nzs_burst)) begin
        run_m = 0;
        nh    = int'(nzs_wait);
      end else run_m = run_m + 1;
    end else if (run_m != 0) begin
      run_m = 0;
      nh    = int'(nzs_wait);
    end
    hold_m = nh;
    if (fs_we && int'(fs_addr) < ORBIT) fill_m[fs_addr] = fs_data;
    bx_m = (bx_m == ORBIT - 1) ? 0 : bx_m + 1;
    @(negedge clk);
  endtask

  // monitor: pops the prediction made LAT edges earlier (R11)
  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() >= LAT) begin
      mon_e = exp_q.pop_front();
      n_chk++;
      if (tfc_word !== mon_e) begin
        n_fail++;
        for (int b = 0; b < 64; b++)
          if (tfc_word[b] !== mon_e[b])
            $display("FAIL %s bit %0d: actual %h expected %h", req_of(b), b, tfc_word, mon_e);
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual run still active, expected finish");
    finish_run();
  end

  initial begin
    for (int k = 0; k < NCMD; k++) begin prev_m[k] = 0; win_m[k] = 0; end
    for (int i = 0; i < ORBIT; i++) fill_m[i] = 0;
    clr();
    cmd_req = '0; fe_wm = 8'd3; be_wm = 8'd2; nzs_wait = 8'd3; nzs_burst = 4'd2;
    rst_n = 0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (tfc_word !== '0) begin // R1
      n_fail++;
      $display("FAIL R1: actual %h expected %h", tfc_word, 64'h0);
    end
    rst_n = 1;

    // R1 R2: idle words carry bunch 0,1,2..., bunch reset on 0
    repeat (5) cyc();

    // R4: low-level accepts with type and destination
    llt_yes = 1; llt_type = 4'd3; dest = 32'hA5A5_0001; cyc();
    llt_type = 4'd7; dest = 32'h1234_5678; cyc();
    clr(); cyc();

    // R4: priority among sources
    llt_yes = 1; per_req = 1; llt_type = 4'd5; dest = 32'h0000_00F0; cyc();
    cal_req = 1; cal_type = 4'd9; dest = 32'h0BAD_CAFE; cyc();
    llt_yes = 0; per_req = 0; cal_type = 4'd2; cyc();
    clr(); per_req = 1; dest = 32'h7; cyc();
    clr(); cyc();

    // R5: throttle rejects every source, calibration included
    throttle = 1; llt_yes = 1; llt_type = 4'd1; dest = 32'hFFFF_FFFF; nzs_req = 1; cyc();
    cal_req = 1; cal_type = 4'd4; cyc();
    throttle = 0; cyc();
    clr(); cyc();

    // R6 R7: pause rejects triggers, synch flag still passes
    pause = 1; llt_yes = 1; llt_type = 4'd6; dest = 32'h55; cmd_req[3] = 1; cyc();
    cyc();
    pause = 0; cmd_req[3] = 0; cyc();
    clr(); cyc();

    // R7 R8: held front-end reset gives one flag and a 3-cycle window
    cmd_req[0] = 1; repeat (6) cyc();
    cmd_req[0] = 0; cyc();
    // R8: back-end reset window reloaded by a second rising edge
    cmd_req[1] = 1; cyc();
    cmd_req[1] = 0; cyc();
    cmd_req[1] = 1; cyc();
    cmd_req[1] = 0; repeat (4) cyc();
    // R7: event-number reset and snapshot together
    cmd_req[2] = 1; cmd_req[4] = 1; cyc();
    cmd_req = '0; repeat (2) cyc();

    // R9 R10 with R8 overlap: NZS burst of 2, third NZS dropped, FE reset mid-burst
    llt_yes = 1; llt_type = 4'd2; nzs_req = 1; dest = 32'h10; cyc();
    cmd_req[0] = 1; cyc();
    cyc();
    cmd_req[0] = 0; cyc();
    clr(); repeat (5) cyc();
    // R10: run of one ends, wait starts after an idle cycle
    llt_yes = 1; nzs_req = 1; dest = 32'h20; cyc();
    clr(); repeat (6) cyc();
    // R9: NZS request under throttle is no event
    llt_yes = 1; nzs_req = 1; throttle = 1; cyc();
    clr(); repeat (2) cyc();

    // R3: mark crossings ahead, write the current one, trigger on a vetoed crossing
    fs_we = 1; fs_data = 1; fs_addr = 12'((bx_m + 3) % ORBIT); cyc();
    fs_addr = 12'((bx_m + 3) % ORBIT); cyc();
    fs_addr = 12'(bx_m); cyc();
    fs_we = 0; cyc();
    llt_yes = 1; llt_type = 4'd8; dest = 32'h99; cyc();
    clr(); repeat (3) cyc();
    fs_we = 1; fs_data = 0; fs_addr = 12'((bx_m + ORBIT - 4) % ORBIT); cyc();
    fs_we = 1; fs_data = 1; fs_addr = 12'd4000; cyc();
    clr();

    // R2 R3: run past the orbit wrap so the marked crossings come round again
    repeat (ORBIT + 20) cyc();

    repeat (LAT + 2) cyc();
    finish_run();
  end

endmodule